// File: doc/BRIEF.md
# Mode-Selectable Serial Baud Generator

This block derives the bit-rate timing of a serial port from the system clock. It divides in two stages. A prescaler divides the clock by 64, 16 or 4, and the ratio follows two mode inputs: a synchronous-select bit and a high-speed bit. An 8-bit period counter then divides the prescaler's enable pulses by (n+1), where n is the value held in a write-only divisor register. Each time the period counter reaches its terminal count, the block emits a one-cycle baud tick.

The rate formulas are therefore clk/(64(n+1)) for asynchronous normal speed, clk/(16(n+1)) for asynchronous high speed, and clk/(4(n+1)) in synchronous mode, where the high-speed bit has no effect. With a 16 MHz clock, n = 25 and asynchronous normal speed, the tick rate is about 9615 Hz.

Writing the divisor register clears both counters at once. The new rate is therefore in force from the write onward, with no wait for the old period to finish. The mode inputs are sampled only at a divisor write and at each terminal count, so a mode change never cuts short the period in progress. In synchronous mode the block also raises a clock-enable output together with each tick.

Top module: `baud_rate_gen`

## Requirements
- R1: With sync_mode=0 and fast_mode=0 in force, consecutive baud_tick pulses are exactly 64*(n+1) clock cycles apart.
- R2: With sync_mode=0 and fast_mode=1 in force, consecutive baud_tick pulses are exactly 16*(n+1) clock cycles apart.
- R3: With sync_mode=1 in force, consecutive baud_tick pulses are exactly 4*(n+1) cycles apart for either value of fast_mode, and sync_clk_en is high in every cycle where baud_tick is high.
- R4: During a period timed in either asynchronous mode, sync_clk_en stays 0.
- R5: A write (div_we=1 at a rising edge) loads div_wdata and clears the prescaler and the period counter. baud_tick is 0 in the cycle after the write, and the first tick appears P cycles after the write edge, where P is the new period.
- R6: Reset (rst=1, synchronous, active high) sets the divisor to 0x00 and the mode to asynchronous normal speed, whatever the mode inputs read. The first tick therefore appears 64 cycles after the last reset edge.
- R7: The mode inputs are sampled only at a divisor write and at a terminal count. A change in the middle of a period leaves that period's length as it was and applies from the next period.
- R8: With n=0 a tick is produced on every prescaler pulse, giving periods of 64, 16 or 4 cycles.
- R9: With n=255 the period is the full 256 prescaler pulses (16384 cycles in asynchronous normal speed).
- R10: baud_tick and sync_clk_en are each high for exactly one cycle per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_we | input | 1 | Divisor register write strobe |
| div_wdata | input | 8 | New divisor value n |
| sync_mode | input | 1 | 1 selects synchronous operation (divide by 4) |
| fast_mode | input | 1 | In asynchronous operation, 1 selects divide by 16 and 0 selects divide by 64 |
| baud_tick | output | 1 | One-cycle pulse per baud period |
| sync_clk_en | output | 1 | One-cycle enable, high with baud_tick in periods timed in synchronous mode |

## Verification
The assertions assume that rst is held high for at least one rising edge before any checked cycle. They also assume that the mode inputs are steady at the edge where a write or a terminal count samples them. The bench changes mode inputs and write data only on falling edges, so every sampling edge sees settled values. The assertions place no limit on write timing. The bench therefore also issues writes in the middle of a period and mode changes between terminal counts, to cover the restart and deferred-mode paths.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int unsigned DIV_W_DEF      = 8;
    localparam int unsigned RATIO_SLOW_DEF = 64;
    localparam int unsigned RATIO_FAST_DEF = 16;
    localparam int unsigned RATIO_SYNC_DEF = 4;

    // Rate mode as latched by the control stage.
    typedef enum logic [1:0] {
        RATE_ASYNC_SLOW = 2'd0,
        RATE_ASYNC_FAST = 2'd1,
        RATE_SYNC       = 2'd2
    } rate_mode_e;

    // Control bundle shared by both counter stages.
    typedef struct packed {
        logic       restart;
        rate_mode_e mode;
    } rate_ctl_t;

    // The synchronous select dominates; the speed bit counts only when asynchronous.
    function automatic rate_mode_e decode_mode(input logic sync_sel, input logic fast_sel);
        rate_mode_e m;
        if (sync_sel)
            m = RATE_SYNC;
        else if (fast_sel)
            m = RATE_ASYNC_FAST;
        else
            m = RATE_ASYNC_SLOW;
        return m;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned r;
        r = (a > b) ? a : b;
        r = (r > c) ? r : c;
        return r;
    endfunction

endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
    import baud_pkg::*;
#(
    parameter int unsigned DIV_W = DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    input  logic             sync_sel,
    input  logic             fast_sel,
    input  logic             period_end,
    output logic [DIV_W-1:0] div_q,
    output rate_ctl_t        ctl
);

    rate_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            mode_q <= RATE_ASYNC_SLOW;
        end else begin
            if (wr_en)
                div_q <= wr_data;
            // Mode is taken only at a period boundary or at a restart.
            if (wr_en || period_end)
                mode_q <= decode_mode(sync_sel, fast_sel);
        end
    end

    always_comb begin
        ctl.restart = wr_en;
        ctl.mode    = mode_q;
    end

endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
    import baud_pkg::*;
#(
    parameter int unsigned PRE_W      = 6,
    parameter int unsigned RATIO_SLOW = RATIO_SLOW_DEF,
    parameter int unsigned RATIO_FAST = RATIO_FAST_DEF,
    parameter int unsigned RATIO_SYNC = RATIO_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  rate_ctl_t        ctl,
    output logic             pulse,
    output logic [PRE_W-1:0] cnt
);

    localparam logic [PRE_W-1:0] LAST_SLOW = PRE_W'(RATIO_SLOW - 1);
    localparam logic [PRE_W-1:0] LAST_FAST = PRE_W'(RATIO_FAST - 1);
    localparam logic [PRE_W-1:0] LAST_SYNC = PRE_W'(RATIO_SYNC - 1);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        case (ctl.mode)
            RATE_ASYNC_FAST: last = LAST_FAST;
            RATE_SYNC:       last = LAST_SYNC;
            default:         last = LAST_SLOW;
        endcase
    end

    assign pulse = (cnt_q == last);
    assign cnt   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || ctl.restart)
            cnt_q <= '0;
        else if (pulse)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + PRE_W'(1);
    end

endmodule

// File: rtl/baud_period.sv
module baud_period
    import baud_pkg::*;
#(
    parameter int unsigned DIV_W = DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  rate_ctl_t        ctl,
    input  logic             pulse,
    input  logic [DIV_W-1:0] div,
    output logic             period_end,
    output logic [DIV_W-1:0] cnt,
    output logic             tick,
    output logic             sync_en
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_last;
    logic             tick_q;
    logic             sync_q;

    assign at_last    = (cnt_q == div);
    assign period_end = pulse && at_last;
    assign cnt        = cnt_q;
    assign tick       = tick_q;
    assign sync_en    = sync_q;

    always_ff @(posedge clk) begin
        if (rst || ctl.restart) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            if (pulse)
                cnt_q <= at_last ? '0 : cnt_q + DIV_W'(1);
            tick_q <= period_end;
            // The enable reflects the mode that timed the finished period.
            sync_q <= period_end && (ctl.mode == RATE_SYNC);
        end
    end

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
    import baud_pkg::*;
#(
    parameter int unsigned DIV_W      = DIV_W_DEF,
    parameter int unsigned RATIO_SLOW = RATIO_SLOW_DEF,
    parameter int unsigned RATIO_FAST = RATIO_FAST_DEF,
    parameter int unsigned RATIO_SYNC = RATIO_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             sync_mode,
    input  logic             fast_mode,
    output logic             baud_tick,
    output logic             sync_clk_en
);

    localparam int unsigned RATIO_MAX = max3(RATIO_SLOW, RATIO_FAST, RATIO_SYNC);
    localparam int unsigned PRE_W     = (RATIO_MAX > 2) ? $clog2(RATIO_MAX) : 1;

    rate_ctl_t        ctl;
    logic [DIV_W-1:0] div_q;
    logic             pre_pulse;
    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] per_cnt;
    logic             period_end;

    baud_ctrl #(
        .DIV_W (DIV_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (div_we),
        .wr_data    (div_wdata),
        .sync_sel   (sync_mode),
        .fast_sel   (fast_mode),
        .period_end (period_end),
        .div_q      (div_q),
        .ctl        (ctl)
    );

    baud_prescale #(
        .PRE_W      (PRE_W),
        .RATIO_SLOW (RATIO_SLOW),
        .RATIO_FAST (RATIO_FAST),
        .RATIO_SYNC (RATIO_SYNC)
    ) u_pre (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .pulse (pre_pulse),
        .cnt   (pre_cnt)
    );

    baud_period #(
        .DIV_W (DIV_W)
    ) u_per (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .pulse      (pre_pulse),
        .div        (div_q),
        .period_end (period_end),
        .cnt        (per_cnt),
        .tick       (baud_tick),
        .sync_en    (sync_clk_en)
    );

endmodule

// File: rtl/baud_rate_gen_chk.sv
module baud_rate_gen_chk
    import baud_pkg::*;
#(
    parameter int unsigned DIV_W      = DIV_W_DEF,
    parameter int unsigned PRE_W      = 6,
    parameter int unsigned RATIO_SLOW = RATIO_SLOW_DEF,
    parameter int unsigned RATIO_FAST = RATIO_FAST_DEF,
    parameter int unsigned RATIO_SYNC = RATIO_SYNC_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             div_we,
    input logic             baud_tick,
    input logic             sync_clk_en,
    input logic [DIV_W-1:0] div_q,
    input rate_mode_e       mode_q,
    input logic             pre_pulse,
    input logic [PRE_W-1:0] pre_cnt,
    input logic [DIV_W-1:0] per_cnt,
    input logic             period_end
);

    logic [PRE_W-1:0] pre_limit;
    always_comb begin
        case (mode_q)
            RATE_ASYNC_FAST: pre_limit = PRE_W'(RATIO_FAST - 1);
            RATE_SYNC:       pre_limit = PRE_W'(RATIO_SYNC - 1);
            default:         pre_limit = PRE_W'(RATIO_SLOW - 1);
        endcase
    end

    // R1 R2 R3: prescaler never runs past the ratio of the mode in force
    p_pre_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        pre_cnt <= pre_limit);

    // R9: period counter never passes the divisor value
    p_per_in_range_r9: assert property (@(posedge clk) disable iff (rst)
        per_cnt <= div_q);

    // R3: synchronous enable only together with a tick
    p_sync_with_tick_r3: assert property (@(posedge clk) disable iff (rst)
        sync_clk_en |-> baud_tick);

    // R4: enable only after a period timed in synchronous mode
    p_async_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        sync_clk_en |-> ($past(mode_q) == RATE_SYNC));

    // R5: a write clears both counters and suppresses the next tick
    p_write_clears_r5: assert property (@(posedge clk) disable iff (rst)
        div_we |=> (pre_cnt == '0 && per_cnt == '0 && !baud_tick));

    // R6: reset state of divisor and mode
    p_reset_state_r6: assert property (@(posedge clk)
        rst |=> (div_q == '0 && mode_q == RATE_ASYNC_SLOW));

    // R7: mode holds between period boundaries and writes
    p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!div_we && !period_end) |=> $stable(mode_q));

    // R8: with a zero divisor every prescaler pulse gives a tick
    p_zero_div_r8: assert property (@(posedge clk) disable iff (rst)
        (pre_pulse && div_q == '0 && !div_we) |=> baud_tick);

    // R10: one-cycle outputs
    p_tick_single_r10: assert property (@(posedge clk) disable iff (rst)
        baud_tick |=> !baud_tick);

endmodule

bind baud_rate_gen baud_rate_gen_chk #(
    .DIV_W      (DIV_W),
    .PRE_W      (PRE_W),
    .RATIO_SLOW (RATIO_SLOW),
    .RATIO_FAST (RATIO_FAST),
    .RATIO_SYNC (RATIO_SYNC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .div_we      (div_we),
    .baud_tick   (baud_tick),
    .sync_clk_en (sync_clk_en),
    .div_q       (div_q),
    .mode_q      (ctl.mode),
    .pre_pulse   (pre_pulse),
    .pre_cnt     (pre_cnt),
    .per_cnt     (per_cnt),
    .period_end  (period_end)
);

// File: tb/baud_rate_gen_tb.sv
module baud_rate_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;
    localparam int MAXWAIT    = 20000;

    // {sync, fast, pad[5:0], n[7:0], expected period[15:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 6'd0, 8'd25,  16'd1664},
        {1'b0, 1'b1, 6'd0, 8'd25,  16'd416},
        {1'b1, 1'b0, 6'd0, 8'd25,  16'd104},
        {1'b1, 1'b1, 6'd0, 8'd25,  16'd104},
        {1'b0, 1'b0, 6'd0, 8'd0,   16'd64},
        {1'b0, 1'b1, 6'd0, 8'd0,   16'd16},
        {1'b1, 1'b0, 6'd0, 8'd0,   16'd4},
        {1'b1, 1'b1, 6'd0, 8'd3,   16'd16},
        {1'b0, 1'b1, 6'd0, 8'd255, 16'd4096},
        {1'b0, 1'b0, 6'd0, 8'd255, 16'd16384}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       div_we = 1'b0;
    logic [7:0] div_wdata = 8'd0;
    logic       sync_mode = 1'b1;
    logic       fast_mode = 1'b1;
    logic       baud_tick;
    logic       sync_clk_en;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    baud_rate_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .div_we      (div_we),
        .div_wdata   (div_wdata),
        .sync_mode   (sync_mode),
        .fast_mode   (fast_mode),
        .baud_tick   (baud_tick),
        .sync_clk_en (sync_clk_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called on a falling edge; returns on the falling edge just after the write edge.
    task automatic write_div(input logic [7:0] n);
        div_wdata = n;
        div_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        div_we    = 1'b0;
        check("R5 no tick right after write", int'(baud_tick), 0);
    endtask

    // Counts falling edges until the next tick is seen.
    task automatic measure(output int cyc, output int en_at_tick, output int stray);
        cyc = 0;
        en_at_tick = 0;
        stray = 0;
        for (int i = 0; i < MAXWAIT; i++) begin
            @(negedge clk);
            cyc++;
            if (baud_tick) begin
                en_at_tick = int'(sync_clk_en);
                break;
            end
            if (sync_clk_en)
                stray++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cyc, en, stray;
        string tag;

        // R6: reset state, with mode inputs at the non-default values
        repeat (3) @(negedge clk);
        check("R6 tick low in reset", int'(baud_tick), 0);
        check("R6 sync enable low in reset", int'(sync_clk_en), 0);
        rst = 1'b0;
        measure(cyc, en, stray);
        check("R6 first period uses divide by 64 and n=0", cyc, 64);
        check("R6 no sync enable in first period", en, 0);
        // R7: mode sampled at that terminal count, so next period is synchronous
        measure(cyc, en, stray);
        check("R7 R8 synchronous period with n=0", cyc, 4);
        check("R3 sync enable with tick", en, 1);

        // Vector table: each row is one mode and divisor
        for (int v = 0; v < NVEC; v++) begin
            logic s, f;
            logic [7:0] n;
            int per;
            s   = VEC[v][31];
            f   = VEC[v][30];
            n   = VEC[v][23:16];
            per = int'(VEC[v][15:0]);
            if (n == 8'd0)        tag = "R8";
            else if (n == 8'd255) tag = "R9";
            else if (s)           tag = "R3";
            else if (f)           tag = "R2";
            else                  tag = "R1";
            sync_mode = s;
            fast_mode = f;
            write_div(n);
            measure(cyc, en, stray);
            check({tag, " R5 first period after write"}, cyc, per);
            check("R3 R4 sync enable at tick follows mode", en, int'(s));
            check("R4 no stray sync enable", stray, 0);
            measure(cyc, en, stray);
            check({tag, " R10 steady period"}, cyc, per);
        end

        // R7: mode change in mid-period does not shorten it
        sync_mode = 1'b0;
        fast_mode = 1'b0;
        write_div(8'd3);
        repeat (100) @(negedge clk);
        sync_mode = 1'b1;
        measure(cyc, en, stray);
        check("R7 current period keeps old mode", cyc, 156);
        check("R7 R4 no sync enable for async period", en, 0);
        measure(cyc, en, stray);
        check("R7 next period uses new mode", cyc, 16);
        check("R7 R3 sync enable in new mode", en, 1);

        // R5: rewrite in mid-period restarts timing at once
        sync_mode = 1'b0;
        fast_mode = 1'b0;
        write_div(8'd10);
        repeat (50) @(negedge clk);
        fast_mode = 1'b1;
        write_div(8'd2);
        measure(cyc, en, stray);
        check("R5 R2 restart after mid-period write", cyc, 48);

        // R6: reset in mid-run clears the divisor
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 tick low during second reset", int'(baud_tick), 0);
        rst = 1'b0;
        measure(cyc, en, stray);
        check("R6 divisor and mode restored by reset", cyc, 64);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule